// File: doc/BRIEF.md
# Row-Strobe Cycle Decoder for a Dual-Port Video Memory

This block watches the control strobes of a dual-port video memory and names each memory cycle as it begins. When the active-low row strobe falls, it samples the two byte column strobes, the transfer select, the write enable and the special-function select. From these it decides whether the cycle is a refresh, a transfer read or a random-port operation. Refreshes and transfers are named at once. Writes and register loads also depend on the special-function select at the first column-strobe fall, so they are held as pending until that edge arrives.

Each decoded cycle gives a one-clock `cyc_valid` pulse with a one-hot cycle type. The block also keeps two sticky mode flags and a stop-point code. Persistent-mask mode is set by a mask-register load. Stop-point mode and its code are set by a stop-point refresh. Only the option-reset refresh clears them. A further flag stays high from reset until the first option-reset refresh, which is the expected first cycle. All pins are sampled synchronously on the system clock.

Top module: `strobe_cycle_decoder`

## Requirements
- R1: After reset, `cyc_valid` is 0, `cyc_onehot` is 0, both mode flags are 0, `stop_code` is 0 and `init_pending` is 1.
- R2: Each decoded cycle raises `cyc_valid` for exactly one clock, in the clock after the edge that sampled it. `cyc_onehot` then has exactly one bit set, at one of these indices: 0 no-op, 1 option-reset refresh, 2 keep refresh, 3 stop-point refresh, 4 full transfer, 5 split transfer, 6 write, 7 masked write, 8 block write, 9 masked block write, 10 mask-register load, 11 color-register load. At all other times `cyc_onehot` is 0.
- R3: The combined column strobe counts as low when either byte strobe, or both, is low. If it is low when the row strobe falls, the cycle is a refresh.
- R4: A refresh with write enable high and special-function select low is the option-reset refresh. It clears both mode flags, sets `stop_code` to 0 and drops `init_pending`.
- R5: A refresh with write enable low and special-function select high is the stop-point refresh. It loads address bits 7:4 into `stop_code` and sets stop-point mode. Address bits 3:0 and 8 have no effect, and persistent-mask mode is left unchanged.
- R6: A refresh with write enable and special-function select both high is the keep refresh. It changes neither flag nor `stop_code`.
- R7: With the column strobe high, transfer select low and write enable high at row fall, the cycle is a transfer read. It is a full transfer when special-function select is low and a split transfer when it is high. It is reported at row fall.
- R8: With the column strobe high and transfer select high at row fall, write enable low with special-function select low starts a masked write, and write enable high with special-function select low starts an unmasked write. The cycle is reported at the first combined column-strobe fall while the row strobe is low. Special-function select high at that fall makes it a block write.
- R9: Transfer select, write enable and special-function select all high at row fall start a register load. At the column fall, special-function select low gives a mask-register load, which sets persistent-mask mode. Special-function select high gives a color-register load, which leaves the flags unchanged.
- R10: Three encodings are reserved: a refresh with write enable and special-function select both low; transfer select low with write enable low; and transfer select high, write enable low, special-function select high. Each reports a no-op and changes no flag and no code.
- R11: If the row strobe rises before the column strobe falls on a pending cycle, no cycle is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ras_n | input | 1 | Row strobe, active low |
| cas_lo_n | input | 1 | Lower byte column strobe, active low |
| cas_hi_n | input | 1 | Upper byte column strobe, active low |
| trg_n | input | 1 | Transfer select, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function select |
| addr | input | ADDR_W | Multiplexed address |
| cyc_valid | output | 1 | One-clock pulse for each decoded cycle |
| cyc_onehot | output | 12 | One-hot cycle type, indices as in R2 |
| persist_mode | output | 1 | Persistent write-mask mode flag |
| stop_mode | output | 1 | Stop-point mode flag |
| stop_code | output | STOP_W | Stored stop-point code |
| init_pending | output | 1 | High until the first option-reset refresh |

## Verification
The assertions assume that each pin holds its value for at least one clock. This means an edge is seen as one low sample after one high sample. The rule that a flag may change only on the cycle type that owns that change also assumes that the mode registers see no reset other than the block reset. The directed stimulus changes pins only on the falling clock edge and holds every level for at least one full clock. It always puts a high row-strobe clock between cycles, and it raises the column strobes before the row strobe falls on every non-refresh cycle. This makes every column fall a clean, separate edge.

// File: rtl/scd_pkg.sv
package scd_pkg;
  localparam int NUM_KINDS = 12;

  typedef enum logic [3:0] {
    K_NOP          = 4'd0,
    K_REF_RESET    = 4'd1,
    K_REF_KEEP     = 4'd2,
    K_REF_STOP     = 4'd3,
    K_XFER_FULL    = 4'd4,
    K_XFER_SPLIT   = 4'd5,
    K_WRITE        = 4'd6,
    K_WRITE_MASKED = 4'd7,
    K_BLOCK        = 4'd8,
    K_BLOCK_MASKED = 4'd9,
    K_LOAD_MASK    = 4'd10,
    K_LOAD_COLOR   = 4'd11
  } kind_e;

  typedef enum logic [1:0] {
    P_NONE     = 2'd0,
    P_WR_PLAIN = 2'd1,
    P_WR_MASK  = 2'd2,
    P_LOAD     = 2'd3
  } pend_e;

  typedef struct packed {
    logic  fire;
    kind_e kind;
    pend_e pend;
  } row_dec_t;
endpackage

// File: rtl/scd_strobe_edge.sv
module scd_strobe_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sig_n,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b1;
      else        prev_q[i] <= sig_n[i];
    end
    assign fall[i] = prev_q[i] & ~sig_n[i];
  end
endmodule

// File: rtl/scd_row_classifier.sv
module scd_row_classifier
  import scd_pkg::*;
(
  input  logic     cas_low,
  input  logic     trg_n,
  input  logic     we_n,
  input  logic     dsf,
  output row_dec_t dec
);
  always_comb begin
    dec.fire = 1'b0;
    dec.kind = K_NOP;
    dec.pend = P_NONE;
    if (cas_low) begin
      dec.fire = 1'b1;
      unique case ({we_n, dsf})
        2'b00:   dec.kind = K_NOP;
        2'b01:   dec.kind = K_REF_STOP;
        2'b10:   dec.kind = K_REF_RESET;
        default: dec.kind = K_REF_KEEP;
      endcase
    end else if (!trg_n) begin
      dec.fire = 1'b1;
      if (we_n) dec.kind = dsf ? K_XFER_SPLIT : K_XFER_FULL;
      else      dec.kind = K_NOP;
    end else begin
      unique case ({we_n, dsf})
        2'b00:   dec.pend = P_WR_MASK;
        2'b10:   dec.pend = P_WR_PLAIN;
        2'b11:   dec.pend = P_LOAD;
        default: dec.fire = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/scd_col_resolver.sv
module scd_col_resolver
  import scd_pkg::*;
(
  input  pend_e pend,
  input  logic  dsf,
  output kind_e kind
);
  always_comb begin
    unique case (pend)
      P_WR_PLAIN: kind = dsf ? K_BLOCK : K_WRITE;
      P_WR_MASK:  kind = dsf ? K_BLOCK_MASKED : K_WRITE_MASKED;
      P_LOAD:     kind = dsf ? K_LOAD_COLOR : K_LOAD_MASK;
      default:    kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/scd_mode_regs.sv
module scd_mode_regs
  import scd_pkg::*;
#(
  parameter int STOP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  kind_e             kind,
  input  logic [STOP_W-1:0] stop_in,
  output logic              persist_mode,
  output logic              stop_mode,
  output logic [STOP_W-1:0] stop_code,
  output logic              init_pending
);
  logic              persist_d, stop_d, init_d;
  logic [STOP_W-1:0] code_d;

  always_comb begin
    persist_d = persist_mode;
    stop_d    = stop_mode;
    code_d    = stop_code;
    init_d    = init_pending;
    if (upd) begin
      unique case (kind)
        K_REF_RESET: begin
          persist_d = 1'b0;
          stop_d    = 1'b0;
          code_d    = '0;
          init_d    = 1'b0;
        end
        K_REF_STOP: begin
          stop_d = 1'b1;
          code_d = stop_in;
        end
        K_LOAD_MASK: persist_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      persist_mode <= 1'b0;
      stop_mode    <= 1'b0;
      stop_code    <= '0;
      init_pending <= 1'b1;
    end else if (upd) begin
      persist_mode <= persist_d;
      stop_mode    <= stop_d;
      stop_code    <= code_d;
      init_pending <= init_d;
    end
  end
endmodule

// File: rtl/strobe_cycle_decoder.sv
module strobe_cycle_decoder
  import scd_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int STOP_LSB = 4,
  parameter int STOP_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ras_n,
  input  logic                 cas_lo_n,
  input  logic                 cas_hi_n,
  input  logic                 trg_n,
  input  logic                 we_n,
  input  logic                 dsf,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 cyc_valid,
  output logic [NUM_KINDS-1:0] cyc_onehot,
  output logic                 persist_mode,
  output logic                 stop_mode,
  output logic [STOP_W-1:0]    stop_code,
  output logic                 init_pending
);
  localparam int SYNC_STAGES = 2;

  // reset: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[SYNC_STAGES-1];

  // combined column strobe: low when either byte strobe is low
  logic       cas_n_all;
  logic [1:0] fall;
  logic       ras_fall, cas_fall;
  assign cas_n_all = cas_lo_n & cas_hi_n;

  scd_strobe_edge #(.N(2)) u_edge (
    .clk   (clk),
    .rst_n (rst_i_n),
    .sig_n ({cas_n_all, ras_n}),
    .fall  (fall)
  );
  assign ras_fall = fall[0];
  assign cas_fall = fall[1];

  row_dec_t row_dec;
  scd_row_classifier u_row (
    .cas_low (~cas_n_all),
    .trg_n   (trg_n),
    .we_n    (we_n),
    .dsf     (dsf),
    .dec     (row_dec)
  );

  pend_e pend_q, pend_d;
  kind_e col_kind;
  scd_col_resolver u_col (
    .pend (pend_q),
    .dsf  (dsf),
    .kind (col_kind)
  );

  logic col_fire, evt_fire;
  kind_e evt_kind;
  assign col_fire = ~ras_n & ~ras_fall & cas_fall & (pend_q != P_NONE);
  assign evt_fire = (ras_fall & row_dec.fire) | col_fire;
  assign evt_kind = ras_fall ? row_dec.kind : col_kind;

  always_comb begin
    pend_d = pend_q;
    if (ras_n)         pend_d = P_NONE;
    else if (ras_fall) pend_d = row_dec.pend;
    else if (cas_fall) pend_d = P_NONE;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) pend_q <= P_NONE;
    else          pend_q <= pend_d;
  end

  // one-hot expansion of the decoded kind
  logic [NUM_KINDS-1:0] onehot_d;
  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_hot
    assign onehot_d[k] = evt_fire & (evt_kind == kind_e'(k));
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cyc_valid  <= 1'b0;
      cyc_onehot <= '0;
    end else begin
      cyc_valid  <= evt_fire;
      cyc_onehot <= onehot_d;
    end
  end

  scd_mode_regs #(.STOP_W(STOP_W)) u_modes (
    .clk          (clk),
    .rst_n        (rst_i_n),
    .upd          (evt_fire),
    .kind         (evt_kind),
    .stop_in      (addr[STOP_LSB +: STOP_W]),
    .persist_mode (persist_mode),
    .stop_mode    (stop_mode),
    .stop_code    (stop_code),
    .init_pending (init_pending)
  );
endmodule

// File: rtl/strobe_cycle_decoder_chk.sv
module strobe_cycle_decoder_chk
  import scd_pkg::*;
#(
  parameter int ADDR_W   = 9,
  parameter int STOP_LSB = 4,
  parameter int STOP_W   = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ras_n,
  input logic [ADDR_W-1:0]    addr,
  input logic                 cyc_valid,
  input logic [NUM_KINDS-1:0] cyc_onehot,
  input logic                 persist_mode,
  input logic                 stop_mode,
  input logic [STOP_W-1:0]    stop_code
);
  assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> $countones(cyc_onehot) == 1);
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid |-> cyc_onehot == '0);
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid);
  assert_row_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> !$past(ras_n));
  assert_persist_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(persist_mode) |-> cyc_valid && cyc_onehot[K_LOAD_MASK]);
  assert_persist_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(persist_mode) |-> cyc_valid && cyc_onehot[K_REF_RESET]);
  assert_stop_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_mode) |-> cyc_valid && cyc_onehot[K_REF_RESET]);
  assert_stop_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_mode) |-> cyc_valid && cyc_onehot[K_REF_STOP]);
  assert_stop_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && cyc_onehot[K_REF_STOP] |-> stop_code == $past(addr[STOP_LSB +: STOP_W]));
  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && cyc_onehot[K_REF_KEEP] |->
      $stable(persist_mode) && $stable(stop_mode) && $stable(stop_code));
  assert_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid && cyc_onehot[K_NOP] |->
      $stable(persist_mode) && $stable(stop_mode) && $stable(stop_code));
endmodule

bind strobe_cycle_decoder strobe_cycle_decoder_chk #(
  .ADDR_W(ADDR_W), .STOP_LSB(STOP_LSB), .STOP_W(STOP_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ras_n        (ras_n),
  .addr         (addr),
  .cyc_valid    (cyc_valid),
  .cyc_onehot   (cyc_onehot),
  .persist_mode (persist_mode),
  .stop_mode    (stop_mode),
  .stop_code    (stop_code)
);

// File: tb/strobe_cycle_decoder_test.sv
module strobe_cycle_decoder_test;
  localparam int NK = 12;
  // cycle-type indices as stated in R2
  localparam int I_NOP = 0, I_REF_RESET = 1, I_REF_KEEP = 2, I_REF_STOP = 3;
  localparam int I_XFULL = 4, I_XSPLIT = 5, I_WR = 6, I_WRM = 7;
  localparam int I_BLK = 8, I_BLKM = 9, I_LMASK = 10, I_LCOLOR = 11;

  logic clk = 1'b0;
  logic rst_n, ras_n, cas_lo_n, cas_hi_n, trg_n, we_n, dsf;
  logic [8:0] addr;
  logic cyc_valid, persist_mode, stop_mode, init_pending;
  logic [NK-1:0] cyc_onehot;
  logic [3:0] stop_code;
  int n_checks = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  strobe_cycle_decoder uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_lo_n(cas_lo_n), .cas_hi_n(cas_hi_n),
    .trg_n(trg_n), .we_n(we_n), .dsf(dsf), .addr(addr),
    .cyc_valid(cyc_valid), .cyc_onehot(cyc_onehot), .persist_mode(persist_mode),
    .stop_mode(stop_mode), .stop_code(stop_code), .init_pending(init_pending)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic chk_modes(input string req, input logic p, input logic s, input logic [3:0] c);
    chk({req, " persist"}, 32'(persist_mode), 32'(p));
    chk({req, " stop"}, 32'(stop_mode), 32'(s));
    chk({req, " code"}, 32'(stop_code), 32'(c));
  endtask

  task automatic end_row();
    ras_n = 1'b1; cas_lo_n = 1'b1; cas_hi_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  // row fall; fire=1 expects a result at row fall, else pending
  task automatic row(input string req, input logic cl, input logic cu, input logic t,
                     input logic w, input logic d, input logic [8:0] a,
                     input logic fire, input int idx);
    cas_lo_n = cl; cas_hi_n = cu; trg_n = t; we_n = w; dsf = d; addr = a; ras_n = 1'b1;
    @(negedge clk);
    ras_n = 1'b0;
    @(negedge clk);
    chk({req, " valid"}, 32'(cyc_valid), 32'(fire));
    chk({req, " type"}, 32'(cyc_onehot), fire ? 32'(1) << idx : 32'd0);
    @(negedge clk);
    chk({req, " pulse ends"}, 32'(cyc_valid), 32'd0);
  endtask

  task automatic col(input string req, input logic d, input int idx);
    dsf = d; cas_lo_n = 1'b0;
    @(negedge clk);
    chk({req, " valid"}, 32'(cyc_valid), 32'd1);
    chk({req, " type"}, 32'(cyc_onehot), 32'(1) << idx);
    @(negedge clk);
    chk({req, " pulse ends"}, 32'(cyc_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 valid", 32'(cyc_valid), 32'd0);
    chk("R1 onehot", 32'(cyc_onehot), 32'd0);
    chk("R1 init", 32'(init_pending), 32'd1);
    chk_modes("R1", 1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_first_refresh();
    row("R4 option refresh", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 9'h0, 1'b1, I_REF_RESET);
    end_row();
    chk("R4 init cleared", 32'(init_pending), 32'd0);
  endtask

  task automatic t_load_mask();
    row("R9 load row", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'h0, 1'b0, 0);
    col("R9 load mask", 1'b0, I_LMASK);
    end_row();
    chk_modes("R9 mask sets", 1'b1, 1'b0, 4'h0);
  endtask

  task automatic t_stop_refresh();
    // upper strobe only (R3); bits 8 and 3:0 set but ignored
    row("R3 R5 stop refresh", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 9'b1_1010_1111, 1'b1, I_REF_STOP);
    end_row();
    chk_modes("R5 stop", 1'b1, 1'b1, 4'hA);
  endtask

  task automatic t_keep_refresh();
    row("R6 keep refresh", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9'h1F0, 1'b1, I_REF_KEEP);
    end_row();
    chk_modes("R6 unchanged", 1'b1, 1'b1, 4'hA);
  endtask

  task automatic t_load_color();
    row("R9 color row", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'h0, 1'b0, 0);
    col("R9 load color", 1'b1, I_LCOLOR);
    end_row();
    chk_modes("R9 color no change", 1'b1, 1'b1, 4'hA);
  endtask

  task automatic t_transfers();
    row("R7 full xfer", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 9'h0, 1'b1, I_XFULL);
    end_row();
    row("R7 split xfer", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 9'h0, 1'b1, I_XSPLIT);
    end_row();
  endtask

  task automatic t_writes();
    row("R8 plain row", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'h0, 1'b0, 0);
    col("R8 write", 1'b0, I_WR);
    end_row();
    row("R8 plain blk row", 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 9'h0, 1'b0, 0);
    col("R8 block", 1'b1, I_BLK);
    end_row();
    row("R8 mask row", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 9'h0, 1'b0, 0);
    col("R8 masked write", 1'b0, I_WRM);
    end_row();
    row("R8 mask blk row", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 9'h0, 1'b0, 0);
    col("R8 masked block", 1'b1, I_BLKM);
    end_row();
  endtask

  task automatic t_reserved();
    row("R10 refresh rsv", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9'h050, 1'b1, I_NOP);
    end_row();
    row("R10 xfer rsv", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 9'h050, 1'b1, I_NOP);
    end_row();
    row("R10 rand rsv", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 9'h050, 1'b1, I_NOP);
    end_row();
    chk_modes("R10 no change", 1'b1, 1'b1, 4'hA);
  endtask

  task automatic t_abandon();
    row("R11 pending row", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 9'h0, 1'b0, 0);
    ras_n = 1'b1;
    @(negedge clk);
    cas_lo_n = 1'b0; dsf = 1'b0;
    @(negedge clk);
    chk("R11 no result", 32'(cyc_valid), 32'd0);
    @(negedge clk);
    chk("R11 no result later", 32'(cyc_valid), 32'd0);
    cas_lo_n = 1'b1;
    @(negedge clk);
    chk_modes("R11 no change", 1'b1, 1'b1, 4'hA);
  endtask

  task automatic t_option_clear();
    row("R4 clear refresh", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 9'h0, 1'b1, I_REF_RESET);
    end_row();
    chk_modes("R4 cleared", 1'b0, 1'b0, 4'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ras_n = 1'b1; cas_lo_n = 1'b1; cas_hi_n = 1'b1;
    trg_n = 1'b1; we_n = 1'b1; dsf = 1'b0; addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_first_refresh();
    t_load_mask();
    t_stop_refresh();
    t_keep_refresh();
    t_load_color();
    t_transfers();
    t_writes();
    t_reserved();
    t_abandon();
    t_option_clear();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule